// File: doc/BRIEF.md
# Real-Time Clock with Field-Masked Alarm and Read Freeze

This block keeps time of day at 1/256-second resolution in four byte-wide fields: subsecond, second, minute and hour. Each accepted rate tick advances the subsecond field, and carries ripple upward through the fields. A set of alarm registers, one per field, is compared against the running time. Each field has its own compare enable. A disabled field is a don't-care, so the alarm repeats at that field's rate for as long as the enabled fields agree.

Software reaches the block through a small synchronous register bus with a combinational read port. It can freeze the visible counters for a consistent multi-byte read. While the counters are frozen, ticks go into a pending counter, and the visible time catches up one step per clock once the freeze is released. Setting the time needs a separate write-enable bit. The freeze, write-enable and clock-enable bits only change when the `prot_ok` input is high during the write, which stands in for an unlock sequence. There are two resets. The power-on reset `por_n` clears everything. The ordinary reset `rst_n` clears only the control state and keeps the time, the alarm values and the compare enables.

Register map: address 0 is control, addresses 1 to 4 are time (subsecond, second, minute, hour), and addresses 5 to 8 are alarm (same field order). Other addresses read 0.

Top module: `rtc_alarm_core`

## Requirements
- R1: Power-on reset (`por_n` low) clears every register, including time, alarm and compare enables. Ordinary reset (`rst_n` low) clears control bits 3..0 (freeze, write enable, flag, clock enable) and the pending count. It leaves the time, the alarm registers and control bits 7..4 unchanged.
- R2: A tick is accepted on a cycle when `tick_en` is 1, control bit 0 (clock enable) is 1, bits 3 and 2 are 0, and the pending count is 0. Each accepted tick advances the subsecond field (address 1) by one in the same clock edge. The subsecond field wraps from 255 to 0 and carries into seconds. With clock enable at 0, ticks are ignored.
- R3: Seconds (address 2) and minutes (address 3) wrap from 59 to 0, and hours (address 4) wraps from 23 to 0. Each wrap carries into the next field.
- R4: Control bits 7, 6, 5 and 4 enable the compare of subsecond, second, minute and hour against alarm addresses 5, 6, 7 and 8. The alarm matches when at least one field is enabled and every enabled field equals its alarm value. The flag (control bit 1) is set one clock after a time update that produces a matching time.
- R5: A field whose compare enable is 0 is ignored. With the subsecond enable at 0, the flag is set again on every time update for as long as the enabled fields match.
- R6: Writing control with bit 1 at 0 clears the flag. Writing bit 1 at 1 has no effect on it. `irq` is 1 exactly when the flag and clock enable are both 1.
- R7: While control bit 3 (freeze) is 1, the visible time stays constant. Accepted-rate ticks are added to a pending count that saturates at 15.
- R8: When freeze is 0 and the pending count is nonzero, the time advances one step per clock and the pending count drops by one. A tick arriving during catch-up leaves the pending count unchanged, so no tick is lost.
- R9: A control write with both bit 3 and bit 2 at 1 leaves both bits at their previous values.
- R10: During the 4 clock edges that follow the edge on which freeze falls, a write that would set bit 3 or bit 2 from 0 to 1 leaves that bit at 0. Clearing either bit is always accepted.
- R11: Control bits 3, 2 and 0 change only on writes with `prot_ok` at 1. Bits 7..4 and the flag clear are written regardless of `prot_ok`.
- R12: Time writes (addresses 1..4) take effect only while control bit 2 (write enable) is 1. A value above the field's maximum loads 0. While write enable is 1, the time does not advance and ticks are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | Ordinary reset, active low, asynchronous |
| tick_en | input | 1 | One-cycle pulse at 256 Hz |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| prot_ok | input | 1 | Permits writes to the protected control bits |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq | output | 1 | Alarm interrupt request |

## Verification
The assertions assume that `tick_en` is a single-cycle pulse and that bus writes are single-cycle strobes with stable address and data. They also assume that software never sets freeze and write enable at the same time through separate writes. The stimulus drives every input on the falling clock edge and holds each tick and write for one cycle with at least one idle cycle between ticks. It keeps freeze and write enable mutually exclusive, which leaves the catch-up and drop rules unambiguous. The bench tracks elapsed ticks as a single integer and derives every expected field arithmetically from it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FIELD_W = 8;
  localparam int NFIELD  = 4;

  // control bit positions (decoded by software)
  localparam int CB_EN_SS = 7;
  localparam int CB_EN_S  = 6;
  localparam int CB_EN_M  = 5;
  localparam int CB_EN_H  = 4;
  localparam int CB_FRZ   = 3;
  localparam int CB_WEN   = 2;
  localparam int CB_FLAG  = 1;
  localparam int CB_RUN   = 0;

  typedef logic [FIELD_W-1:0] field_t;
  typedef logic [NFIELD-1:0][FIELD_W-1:0] rtc_time_t;

  function automatic field_t wrap_inc(input field_t v, input field_t last);
    return (v >= last) ? '0 : v + field_t'(1);
  endfunction

  function automatic field_t clamp_load(input field_t v, input field_t last);
    return (v > last) ? '0 : v;
  endfunction

  function automatic logic field_hit(input logic en, input field_t t, input field_t a);
    return !en || (t == a);
  endfunction
endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
#(
  parameter int SEC_LAST = 59,
  parameter int MIN_LAST = 59,
  parameter int HR_LAST  = 23
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              step,
  input  logic [NFIELD-1:0] wr_stb,
  input  field_t            wdata,
  output rtc_time_t         cnt_o
);
  localparam rtc_time_t LAST = {field_t'(HR_LAST), field_t'(MIN_LAST),
                                field_t'(SEC_LAST), field_t'((1 << FIELD_W) - 1)};

  logic [NFIELD:0] carry;
  assign carry[0] = step;

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    field_t q;
    assign cnt_o[g]    = q;
    assign carry[g+1]  = carry[g] && (q == LAST[g]);

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)          q <= '0;
      else if (wr_stb[g])  q <= clamp_load(wdata, LAST[g]);
      else if (carry[g])   q <= wrap_inc(q, LAST[g]);
    end

    // R3: a field never holds a value above its maximum
    a_r3_in_range: assert property (@(posedge clk) disable iff (!por_n)
      q <= LAST[g]);
    // R2: advancing from the last value returns to zero
    a_r2_wrap: assert property (@(posedge clk) disable iff (!por_n)
      carry[g] && (q == LAST[g]) && !wr_stb[g] |=> q == '0);
  end
endmodule

// File: rtl/rtc_freeze_ctrl.sv
module rtc_freeze_ctrl #(
  parameter int PEND_W = 4
) (
  input  logic clk,
  input  logic rst_any_n,
  input  logic tick,
  input  logic run,
  input  logic frz,
  input  logic wen,
  output logic step
);
  logic [PEND_W-1:0] pend;
  logic tick_ok, have, sat;

  assign tick_ok = tick && run && !wen;
  assign have    = (pend != '0);
  assign sat     = &pend;
  assign step    = !wen && !frz && (have || tick_ok);

  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n) pend <= '0;
    else if (frz) begin
      if (tick_ok && !sat) pend <= pend + 1'b1;
    end else if (!wen && have && !tick_ok) begin
      pend <= pend - 1'b1;
    end
  end

  // R7: frozen counters never step
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_any_n)
    frz |-> !step);
  // R7: a tick while frozen is banked
  a_r7_bank: assert property (@(posedge clk) disable iff (!rst_any_n)
    frz && tick_ok && !sat |=> pend == $past(pend) + 1'b1);
  // R8: catch-up drains one per cycle
  a_r8_drain: assert property (@(posedge clk) disable iff (!rst_any_n)
    !frz && !wen && have && !tick_ok |=> pend == $past(pend) - 1'b1);
endmodule

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_pkg::*;
#(
  parameter int HOLDOFF = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_any_n,
  input  logic              wr,
  input  field_t            wdata,
  input  logic              prot_ok,
  input  logic              match_evt,
  output field_t            ctrl_o,
  output logic [NFIELD-1:0] en_o,
  output logic              frz_o,
  output logic              wen_o,
  output logic              run_o,
  output logic              flag_o
);
  localparam int HW = $clog2(HOLDOFF + 1);

  logic [NFIELD-1:0] en;
  logic frz, wen, run, flag;
  logic frz_n, wen_n, flag_n;
  logic [HW-1:0] hold;
  logic busy, both, acc;

  assign busy = (hold != '0);
  assign both = wdata[CB_FRZ] && wdata[CB_WEN];
  assign acc  = wr && prot_ok && !both;

  always_comb begin
    frz_n = frz;
    wen_n = wen;
    if (acc) begin
      if (!wdata[CB_FRZ])  frz_n = 1'b0;
      else if (!busy)      frz_n = 1'b1;
      if (!wdata[CB_WEN])  wen_n = 1'b0;
      else if (!busy)      wen_n = 1'b1;
    end
    flag_n = flag;
    if (wr && !wdata[CB_FLAG]) flag_n = 1'b0;
    if (match_evt)             flag_n = 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)  en <= '0;
    else if (wr) en <= {wdata[CB_EN_H], wdata[CB_EN_M], wdata[CB_EN_S], wdata[CB_EN_SS]};
  end

  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n) begin
      frz  <= 1'b0;
      wen  <= 1'b0;
      run  <= 1'b0;
      flag <= 1'b0;
      hold <= '0;
    end else begin
      frz  <= frz_n;
      wen  <= wen_n;
      flag <= flag_n;
      if (wr && prot_ok) run <= wdata[CB_RUN];
      if (frz && !frz_n) hold <= HW'(HOLDOFF);
      else if (busy)     hold <= hold - 1'b1;
    end
  end

  assign en_o   = en;
  assign frz_o  = frz;
  assign wen_o  = wen;
  assign run_o  = run;
  assign flag_o = flag;
  assign ctrl_o = {en[0], en[1], en[2], en[3], frz, wen, flag, run};

  // R9: setting both mode bits at once is refused
  a_r9_both: assert property (@(posedge clk) disable iff (!rst_any_n)
    wr && both |=> frz == $past(frz) && wen == $past(wen));
  // R11: protected bits hold without permission
  a_r11_prot: assert property (@(posedge clk) disable iff (!rst_any_n)
    wr && !prot_ok |=> frz == $past(frz) && wen == $past(wen) && run == $past(run));
  // R10: no re-arm of freeze during the holdoff window
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_any_n)
    busy && !frz && wr |=> !frz);
  // R6: the flag only rises from a match event
  a_r6_src: assert property (@(posedge clk) disable iff (!rst_any_n)
    $rose(flag) |-> $past(match_evt));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_pkg::*;
(
  input  rtc_time_t         cnt,
  input  rtc_time_t         alm,
  input  logic [NFIELD-1:0] en,
  output logic              match
);
  logic [NFIELD-1:0] hit;
  for (genvar g = 0; g < NFIELD; g++) begin : g_hit
    assign hit[g] = field_hit(en[g], cnt[g], alm[g]);
  end
  assign match = (|en) && (&hit);
endmodule

// File: rtl/rtc_alarm_core.sv
module rtc_alarm_core
  import rtc_pkg::*;
#(
  parameter int SEC_LAST = 59,
  parameter int MIN_LAST = 59,
  parameter int HR_LAST  = 23,
  parameter int PEND_W   = 4,
  parameter int HOLDOFF  = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       bus_wr,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       prot_ok,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_TIME = 4'd1;
  localparam logic [3:0] A_ALM  = 4'd5;

  logic rst_any_n;
  assign rst_any_n = por_n && rst_n;

  field_t ctrl;
  logic [NFIELD-1:0] en, wr_time;
  logic frz, wen, run, flag, step, match, adv_q, match_evt;
  rtc_time_t cnt, alm;

  for (genvar g = 0; g < NFIELD; g++) begin : g_alm
    field_t a;
    assign alm[g]     = a;
    assign wr_time[g] = bus_wr && wen && (bus_addr == A_TIME + 4'(g));
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) a <= '0;
      else if (bus_wr && (bus_addr == A_ALM + 4'(g))) a <= bus_wdata;
    end
  end

  rtc_ctrl_reg #(.HOLDOFF(HOLDOFF)) u_ctrl (
    .clk(clk), .por_n(por_n), .rst_any_n(rst_any_n),
    .wr(bus_wr && (bus_addr == A_CTRL)), .wdata(bus_wdata), .prot_ok(prot_ok),
    .match_evt(match_evt), .ctrl_o(ctrl), .en_o(en), .frz_o(frz),
    .wen_o(wen), .run_o(run), .flag_o(flag)
  );

  rtc_freeze_ctrl #(.PEND_W(PEND_W)) u_frz (
    .clk(clk), .rst_any_n(rst_any_n), .tick(tick_en), .run(run),
    .frz(frz), .wen(wen), .step(step)
  );

  rtc_time_chain #(.SEC_LAST(SEC_LAST), .MIN_LAST(MIN_LAST), .HR_LAST(HR_LAST)) u_time (
    .clk(clk), .por_n(por_n), .step(step), .wr_stb(wr_time),
    .wdata(bus_wdata), .cnt_o(cnt)
  );

  rtc_alarm_match u_match (.cnt(cnt), .alm(alm), .en(en), .match(match));

  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n) adv_q <= 1'b0;
    else            adv_q <= step;
  end
  assign match_evt = adv_q && match;
  assign irq       = flag && run;

  always_comb begin
    case (bus_addr)
      4'd0:    bus_rdata = ctrl;
      4'd1:    bus_rdata = cnt[0];
      4'd2:    bus_rdata = cnt[1];
      4'd3:    bus_rdata = cnt[2];
      4'd4:    bus_rdata = cnt[3];
      4'd5:    bus_rdata = alm[0];
      4'd6:    bus_rdata = alm[1];
      4'd7:    bus_rdata = alm[2];
      4'd8:    bus_rdata = alm[3];
      default: bus_rdata = '0;
    endcase
  end

  // R4: a matching update raises the flag on the next edge
  a_r4_set: assert property (@(posedge clk) disable iff (!rst_any_n)
    adv_q && match |=> flag);
  // R12: write enable stops the time from advancing
  a_r12_still: assert property (@(posedge clk) disable iff (!rst_any_n)
    wen && !(|wr_time) |=> $stable(cnt));
endmodule

// File: tb/tb_rtc_alarm_core.sv
module tb_rtc_alarm_core;
  logic clk = 1'b0;
  logic por_n, rst_n, tick_en, bus_wr, prot_ok, irq;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;

  int n_chk = 0, n_err = 0;
  int tval = 0;
  localparam int DAY = 256 * 86400;

  always #4 clk = ~clk;

  rtc_alarm_core dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .prot_ok(prot_ok),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input bit p = 1'b1);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; prot_ok = p;
    @(negedge clk);
    bus_wr = 1'b0; prot_ok = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_en = 1'b1;
      @(negedge clk) tick_en = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_time(input int t);
    return {8'(t / 921600 % 24), 8'(t / 15360 % 60), 8'(t / 256 % 60), 8'(t % 256)};
  endfunction

  task automatic chk_time(input string req);
    logic [7:0] f0, f1, f2, f3;
    rd(4'd1, f0); rd(4'd2, f1); rd(4'd3, f2); rd(4'd4, f3);
    chk(req, {f3, f2, f1, f0}, exp_time(tval));
  endtask

  task automatic set_time(input int h, input int m, input int s, input int ss);
    wr(4'd0, 8'h05);
    wr(4'd4, 8'(h)); wr(4'd3, 8'(m)); wr(4'd2, 8'(s)); wr(4'd1, 8'(ss));
    tval = ((h * 60 + m) * 60 + s) * 256 + ss;
  endtask

  initial begin
    #1500000;
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] d;
    por_n = 0; rst_n = 0; tick_en = 0; bus_wr = 0; prot_ok = 0;
    bus_addr = '0; bus_wdata = '0;
    idle(3);
    por_n = 1; rst_n = 1;
    idle(1);

    // R1: power-on state
    rd(4'd0, d); chk("R1 ctrl after por", d, 8'h00);
    chk_time("R1 time after por");
    chk("R1 irq after por", irq, 0);

    // R12: write enable and clamping
    wr(4'd0, 8'h05);
    rd(4'd0, d); chk("R12 wen set", d, 8'h05);
    wr(4'd2, 8'd70);
    rd(4'd2, d); chk("R12 clamp above max", d, 8'd0);
    set_time(23, 59, 59, 250);
    tick(3);
    chk_time("R12 no advance with wen");
    wr(4'd0, 8'h01);
    wr(4'd2, 8'd5);
    chk_time("R12 time write ignored without wen");

    // R2 R3: carry sweep across midnight
    for (int i = 0; i < 400; i++) begin
      tick(1);
      tval = (tval + 1) % DAY;
      chk_time("R2 R3 sweep");
    end

    // R11: clock enable is protected; R2: halted clock ignores ticks
    wr(4'd0, 8'h00, 1'b0);
    rd(4'd0, d); chk("R11 run kept without prot", d, 8'h01);
    wr(4'd0, 8'h00);
    tick(2);
    chk_time("R2 no advance when run off");
    wr(4'd0, 8'h09, 1'b0);
    rd(4'd0, d); chk("R11 freeze refused without prot", d, 8'h00);
    wr(4'd0, 8'h01);

    // R4: all fields enabled
    set_time(10, 20, 30, 5);
    wr(4'd0, 8'h01);
    wr(4'd5, 8'd8); wr(4'd6, 8'd30); wr(4'd7, 8'd20); wr(4'd8, 8'd10);
    wr(4'd0, 8'hF1);
    tick(2); tval += 2; idle(1);
    rd(4'd0, d); chk("R4 no flag before match", d[1], 0);
    tick(1); tval += 1; idle(1);
    rd(4'd0, d); chk("R4 flag on full match", d[1], 1);
    chk("R6 irq with flag and run", irq, 1);
    tick(1); tval += 1; idle(1);
    rd(4'd0, d); chk("R6 flag sticky", d[1], 1);

    // R6: clear and write-one
    wr(4'd0, 8'hF1);
    rd(4'd0, d); chk("R6 flag cleared", d, 8'hF1);
    wr(4'd0, 8'hF3);
    rd(4'd0, d); chk("R6 write one no effect", d[1], 0);
    chk("R6 irq low", irq, 0);

    // R5: seconds only, repeats every subsecond step
    wr(4'd0, 8'h41);
    tick(1); tval += 1; idle(1);
    rd(4'd0, d); chk("R5 flag seconds match", d[1], 1);
    wr(4'd0, 8'h41);
    tick(1); tval += 1; idle(1);
    rd(4'd0, d); chk("R5 flag repeats next step", d[1], 1);
    wr(4'd0, 8'h42);
    chk("R6 irq gated by run", irq, 0);
    rd(4'd0, d); chk("R6 flag kept with run off", d[1], 1);
    wr(4'd0, 8'h01);

    // R4 R5: subsecond-only sweep over a full second
    wr(4'd0, 8'h81);
    for (int i = 0; i < 256; i++) begin
      tick(1); tval += 1; idle(1);
      rd(4'd0, d);
      chk("R4 R5 subsecond sweep", d[1], ((tval % 256) == 8) ? 1 : 0);
      wr(4'd0, 8'h81);
    end
    wr(4'd0, 8'h01);
    chk_time("R3 after sweep");

    // R7 R8: freeze and catch-up
    wr(4'd0, 8'h09);
    tick(3);
    chk_time("R7 frozen time");
    wr(4'd0, 8'h01);
    // R10: re-arm inside holdoff refused
    wr(4'd0, 8'h09);
    rd(4'd0, d); chk("R10 freeze refused in holdoff", d, 8'h01);
    wr(4'd0, 8'h05);
    rd(4'd0, d); chk("R10 wen refused in holdoff", d, 8'h01);
    idle(6);
    tval += 3;
    chk_time("R8 catch-up");
    wr(4'd0, 8'h09);
    rd(4'd0, d); chk("R10 freeze accepted after holdoff", d, 8'h09);
    tick(20);
    chk_time("R7 frozen during long hold");
    wr(4'd0, 8'h01);
    tick(4);
    idle(25);
    tval += 19;
    chk_time("R7 R8 saturation and tick during catch-up");

    // R9: both mode bits at once
    wr(4'd0, 8'h0D);
    rd(4'd0, d); chk("R9 both bits ignored", d, 8'h01);

    // R1: ordinary reset
    wr(4'd0, 8'hF9);
    tick(2);
    idle(1);
    rst_n = 0; idle(1); rst_n = 1; idle(1);
    rd(4'd0, d); chk("R1 ctrl after ordinary reset", d, 8'hF0);
    chk_time("R1 time kept");
    rd(4'd5, d); chk("R1 alarm kept", d, 8'd8);
    chk("R1 irq after ordinary reset", irq, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule